// File: doc/BRIEF.md
# Quad-Channel Converter Register and Update Controller

This block keeps the digital state behind a four-channel digital-to-analog converter. Every channel has a staging (input) code register, an active (output) code register and a two-bit power mode. Around them sit a global clear-code selector and a per-channel bypass mask that picks whether a channel waits for the hardware load pin or takes each new code at once. Complete 32-bit command frames arrive already assembled, one per `frame_valid` cycle. The block decodes them into register actions and drives the active codes and power modes to the analog side.

Three level inputs shape the behaviour. `load_n` moves staged codes into the active registers. A falling edge on `clear_n` forces every code to a preset value. `rst_mid` selects whether a reset lands on zero or on midscale. All state updates on the rising clock edge. Outputs come straight from registers, so a frame or pin event shows on the ports one cycle after the edge that samples it.

Top module: `quad_dac_regctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all staging and active codes load 0x0000 (`rst_mid`=0) or 0x8000 (`rst_mid`=1). All power modes become 00, the bypass mask becomes 0000 and the clear code becomes 00. Load and clear activity during reset has no effect, and a `clear_n` that is already low when reset releases is not a falling edge.
- R2: The frame fields are: command in bits 27:24, channel address in bits 23:20, code in bits 19:4 (MSB at bit 19). Command 0000 writes the staging register of the addressed channel and leaves its active code alone unless R6 or R7 applies.
- R3: Command 0001 copies the staging code of the addressed channel into its active register. Command 0011 writes the staging code and copies it into the active register in the same cycle.
- R4: Command 0010 writes the addressed staging register. It then copies every channel's staging code, including the new value, into the active registers.
- R5: Address 0..3 selects channel A..D and address 1111 selects all channels. Any other address makes commands 0000-0011 do nothing.
- R6: While `load_n` is low and `clear_n` is high, every channel whose mask bit is 0 copies its staging code (after any write in the same cycle) into its active register.
- R7: Command 0110 loads the bypass mask from bits 3:0 (bit 0 = A ... bit 3 = D). A channel with mask bit 1 ignores `load_n`, and its active code follows each write to its staging register in the same cycle.
- R8: Command 0101 loads the clear code from bits 1:0. A falling edge on `clear_n` loads every staging and active register with 0x0000 (code 00), 0x8000 (01) or 0xFFFF (10). Code 11 does nothing. While `clear_n` is low, `load_n` is ignored.
- R9: A frame in the same cycle as a clear falling edge with a clear code other than 11 is dropped.
- R10: Command 0100 sets the power mode from bits 9:8 (00 normal, 01 1 kOhm to ground, 10 100 kOhm to ground, 11 three-state) on every channel whose bit in 3:0 is set (bit 0 = A). Codes are untouched. `pwr_mode` carries channel A in bits 1:0.
- R11: Command 0111 restores the full R1 state using the current `rst_mid`. Command 1000 and commands 1001-1111 change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| rst_mid | input | 1 | Reset target: 0 zero scale, 1 midscale |
| frame_valid | input | 1 | A committed frame is present this cycle |
| frame_data | input | 32 | Committed command frame |
| load_n | input | 1 | Hardware load, active low level |
| clear_n | input | 1 | Clear, acts on its falling edge |
| out_code | output | 64 | Active codes, channel A in bits 15:0 |
| pwr_mode | output | 8 | Power modes, two bits per channel, A lowest |

## Verification
The assertions take `rst_mid` as steady across the cycle in which reset releases. They also assume that `clear_n` and `load_n` move only between clock edges, so one sample per edge sees every level the block acts on. The no-effect properties hold only when `load_n` is high and no clear edge arrives in the same cycle, because either of those may legally move the active codes. The stimulus changes every input at the falling clock edge, keeps `rst_mid` fixed while reset is released, and places load pulses, clear edges and frames in separate cycles, except for the single case that checks a clear dropping a frame.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    typedef enum logic [3:0] {
        CMD_WR_IN      = 4'h0,
        CMD_UPD        = 4'h1,
        CMD_WR_UPD_ALL = 4'h2,
        CMD_WR_UPD     = 4'h3,
        CMD_PWR        = 4'h4,
        CMD_CLR_CODE   = 4'h5,
        CMD_MASK       = 4'h6,
        CMD_SOFT_RST   = 4'h7,
        CMD_CHAIN      = 4'h8
    } qdac_cmd_e;

    localparam int CMD_MSB  = 27;
    localparam int ADDR_MSB = 23;
    localparam int DATA_MSB = 19;
    localparam int PWR_MSB  = 9;
    localparam logic [3:0] ADDR_ALL = 4'hF;
endpackage

// File: rtl/qdac_addr_dec.sv
module qdac_addr_dec #(
    parameter int NCH = 4
) (
    input  logic [3:0]     addr,
    output logic [NCH-1:0] sel
);
    for (genvar i = 0; i < NCH; i++) begin : g_sel
        assign sel[i] = (addr == 4'(i)) || (addr == qdac_pkg::ADDR_ALL);
    end
endmodule

// File: rtl/qdac_clr_val.sv
module qdac_clr_val #(
    parameter int DW = 16
) (
    input  logic [1:0]    code,
    output logic [DW-1:0] val,
    output logic          active
);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    always_comb begin
        active = 1'b1;
        case (code)
            2'b00:   val = '0;
            2'b01:   val = MID;
            2'b10:   val = '1;
            default: begin
                val    = '0;
                active = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/quad_dac_regctl.sv
module quad_dac_regctl #(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_mid,
    input  logic              frame_valid,
    input  logic [31:0]       frame_data,
    input  logic              load_n,
    input  logic              clear_n,
    output logic [NCH*DW-1:0] out_code,
    output logic [2*NCH-1:0]  pwr_mode
);
    import qdac_pkg::*;

    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] in_code;
        logic [NCH-1:0][DW-1:0] act_code;
        logic [NCH-1:0][1:0]    pwr;
        logic [NCH-1:0]         bypass;
        logic [1:0]             clr_code;
        logic                   clr_prev;
    } state_t;

    state_t st_d, st_q;

    logic [3:0]     f_cmd;
    logic [3:0]     f_addr;
    logic [DW-1:0]  f_data;
    logic [NCH-1:0] sel;
    logic [DW-1:0]  clr_val;
    logic           clr_active;
    logic [1:0]     clr_code_q;
    wire            unused_bits = &{1'b0, frame_data[31:28]};

    assign f_cmd      = frame_data[CMD_MSB -: 4];
    assign f_addr     = frame_data[ADDR_MSB -: 4];
    assign f_data     = frame_data[DATA_MSB -: DW];
    assign clr_code_q = st_q.clr_code;

    qdac_addr_dec #(.NCH(NCH)) u_dec (
        .addr (f_addr),
        .sel  (sel)
    );

    qdac_clr_val #(.DW(DW)) u_clr (
        .code   (st_q.clr_code),
        .val    (clr_val),
        .active (clr_active)
    );

    function automatic state_t reset_image(input logic mid, input logic clr_now);
        state_t s;
        for (int i = 0; i < NCH; i++) begin
            s.in_code[i]  = mid ? MID : '0;
            s.act_code[i] = mid ? MID : '0;
            s.pwr[i]      = 2'b00;
        end
        s.bypass   = '0;
        s.clr_code = 2'b00;
        s.clr_prev = clr_now;
        return s;
    endfunction

    always_comb begin
        logic           clr_fall;
        logic           do_clr;
        logic [NCH-1:0] written;

        st_d          = st_q;
        st_d.clr_prev = clear_n;
        written       = '0;
        clr_fall      = st_q.clr_prev & ~clear_n;
        do_clr        = clr_fall & clr_active;

        if (do_clr) begin
            for (int i = 0; i < NCH; i++) begin
                st_d.in_code[i]  = clr_val;
                st_d.act_code[i] = clr_val;
            end
        end else if (frame_valid) begin
            case (qdac_cmd_e'(f_cmd))
                CMD_WR_IN, CMD_WR_UPD, CMD_WR_UPD_ALL: begin
                    for (int i = 0; i < NCH; i++) begin
                        if (sel[i]) begin
                            st_d.in_code[i] = f_data;
                            written[i]      = 1'b1;
                        end
                    end
                    if (f_cmd == CMD_WR_UPD) begin
                        for (int i = 0; i < NCH; i++) begin
                            if (sel[i]) st_d.act_code[i] = f_data;
                        end
                    end
                    if (f_cmd == CMD_WR_UPD_ALL && |sel) begin
                        st_d.act_code = st_d.in_code;
                    end
                    for (int i = 0; i < NCH; i++) begin
                        if (written[i] && st_q.bypass[i]) st_d.act_code[i] = f_data;
                    end
                end
                CMD_UPD: begin
                    for (int i = 0; i < NCH; i++) begin
                        if (sel[i]) st_d.act_code[i] = st_q.in_code[i];
                    end
                end
                CMD_PWR: begin
                    for (int i = 0; i < NCH; i++) begin
                        if (frame_data[i]) st_d.pwr[i] = frame_data[PWR_MSB -: 2];
                    end
                end
                CMD_CLR_CODE: st_d.clr_code = frame_data[1:0];
                CMD_MASK:     st_d.bypass   = frame_data[NCH-1:0];
                CMD_SOFT_RST: st_d = reset_image(rst_mid, clear_n);
                default: ;
            endcase
        end

        if (!load_n && clear_n && !do_clr) begin
            for (int i = 0; i < NCH; i++) begin
                if (!st_d.bypass[i]) st_d.act_code[i] = st_d.in_code[i];
            end
        end

        if (!rst_n) st_d = reset_image(rst_mid, clear_n);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_code = st_q.act_code;
    assign pwr_mode = st_q.pwr;
endmodule

// File: rtl/qdac_chk.sv
module qdac_chk #(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_mid,
    input logic              frame_valid,
    input logic [31:0]       frame_data,
    input logic              load_n,
    input logic              clear_n,
    input logic [NCH*DW-1:0] out_code,
    input logic [2*NCH-1:0]  pwr_mode,
    input logic [1:0]        clr_code
);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    logic       clr_seen;
    logic       fall;
    logic [3:0] cmd;
    logic [3:0] addr;
    wire        unused_chk = &{1'b0, frame_data[31:28], frame_data[19:0]};

    always_ff @(posedge clk) clr_seen <= clear_n;

    assign fall = clr_seen & ~clear_n;
    assign cmd  = frame_data[27:24];
    assign addr = frame_data[23:20];

    function automatic logic [DW-1:0] clr_value(input logic [1:0] c);
        return (c == 2'b00) ? '0 : (c == 2'b01) ? MID : '1;
    endfunction

    assert_reset_image_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pwr_mode == '0 && out_code == {NCH{rst_mid ? MID : {DW{1'b0}}}}));

    assert_bad_addr_noop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && cmd <= 4'h3 && addr >= 4'h4 && addr <= 4'hE && load_n && !fall)
        |=> $stable(out_code));

    assert_clear_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && clr_code != 2'b11) |=> out_code == {NCH{clr_value($past(clr_code))}});

    assert_clear_blocks_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_n && !clr_seen && !frame_valid) |=> $stable(out_code));

    assert_pwr_keeps_codes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && cmd == 4'h4 && load_n && !fall) |=> $stable(out_code));

    assert_reserved_noop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && cmd >= 4'h8 && load_n && !fall)
        |=> ($stable(out_code) && $stable(pwr_mode)));
endmodule

bind quad_dac_regctl qdac_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_mid     (rst_mid),
    .frame_valid (frame_valid),
    .frame_data  (frame_data),
    .load_n      (load_n),
    .clear_n     (clear_n),
    .out_code    (out_code),
    .pwr_mode    (pwr_mode),
    .clr_code    (clr_code_q)
);

// File: tb/quad_dac_regctl_tb.sv
module quad_dac_regctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_mid = 1'b0;
    logic        frame_valid = 1'b0;
    logic [31:0] frame_data = '0;
    logic        load_n = 1'b1;
    logic        clear_n = 1'b1;
    logic [63:0] out_code;
    logic [7:0]  pwr_mode;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_dac_regctl u_dut (
        .clk(clk), .rst_n(rst_n), .rst_mid(rst_mid), .frame_valid(frame_valid),
        .frame_data(frame_data), .load_n(load_n), .clear_n(clear_n),
        .out_code(out_code), .pwr_mode(pwr_mode)
    );

    function automatic logic [31:0] fr(input logic [3:0] c, input logic [3:0] a,
                                       input logic [15:0] d);
        return {4'h0, c, a, d, 4'h0};
    endfunction

    // Vectors: frame, expected out {D,C,B,A}, expected pwr_mode
    localparam logic [31:0] VF [NV] = '{
        fr(4'h0, 4'h0, 16'h1111), fr(4'h1, 4'h0, 16'h0), fr(4'h3, 4'h1, 16'h2222),
        fr(4'h0, 4'h2, 16'h3333), fr(4'h0, 4'h3, 16'h4444), fr(4'h2, 4'h0, 16'h5555),
        fr(4'h0, 4'hF, 16'h6666), fr(4'h0, 4'h5, 16'h7777), fr(4'h1, 4'hF, 16'h0),
        fr(4'h9, 4'h0, 16'h1234), fr(4'hF, 4'hF, 16'hABCD), fr(4'h1, 4'h0, 16'h0),
        32'h0400_0205, 32'h0600_0002, fr(4'h0, 4'h1, 16'h8888),
        32'h0800_0002, 32'h0400_0308
    };
    localparam logic [63:0] VO [NV] = '{
        64'h0000_0000_0000_0000, 64'h0000_0000_0000_1111, 64'h0000_0000_2222_1111,
        64'h0000_0000_2222_1111, 64'h0000_0000_2222_1111, 64'h4444_3333_2222_5555,
        64'h4444_3333_2222_5555, 64'h4444_3333_2222_5555, 64'h6666_6666_6666_6666,
        64'h6666_6666_6666_6666, 64'h6666_6666_6666_6666, 64'h6666_6666_6666_6666,
        64'h6666_6666_6666_6666, 64'h6666_6666_6666_6666, 64'h6666_6666_8888_6666,
        64'h6666_6666_8888_6666, 64'h6666_6666_8888_6666
    };
    localparam logic [7:0] VP [NV] = '{
        8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
        8'h00, 8'h00, 8'h00, 8'h22, 8'h22, 8'h22, 8'h22, 8'hE2
    };
    localparam string VT [NV] = '{
        "R2", "R3", "R3", "R2", "R2", "R4", "R5", "R5", "R5",
        "R11", "R11", "R11", "R10", "R7", "R7", "R11", "R10"
    };

    task automatic chk(input string tag, input logic [63:0] eo, input logic [7:0] ep);
        checks++;
        if (out_code !== eo || pwr_mode !== ep) begin
            fails++;
            $display("FAIL %s: out=%h pwr=%h expected out=%h pwr=%h", tag, out_code, pwr_mode, eo, ep);
        end
    endtask

    task automatic send(input logic [31:0] f);
        frame_valid = 1'b1;
        frame_data  = f;
        @(negedge clk);
        frame_valid = 1'b0;
        frame_data  = '0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) tick();
        chk("R1 reset zero", 64'h0, 8'h00);
        rst_n = 1'b1;
        tick();

        for (int k = 0; k < NV; k++) begin
            send(VF[k]);
            chk(VT[k], VO[k], VP[k]);
        end

        // R7: bypassed channel B follows write without load pulse
        send(fr(4'h0, 4'hF, 16'h9999));
        chk("R7 bypass", 64'h6666_6666_9999_6666, 8'hE2);
        // R6: load pin copies staged codes
        load_n = 1'b0; tick(); load_n = 1'b1;
        chk("R6 load", 64'h9999_9999_9999_9999, 8'hE2);
        // R8: clear code 01 then falling edge
        send(32'h0500_0001);
        clear_n = 1'b0; tick();
        chk("R8 clear mid", 64'h8000_8000_8000_8000, 8'hE2);
        // R8: load ignored while clear low
        send(fr(4'h0, 4'h0, 16'h1234));
        load_n = 1'b0; tick(); load_n = 1'b1;
        chk("R8 load blocked", 64'h8000_8000_8000_8000, 8'hE2);
        clear_n = 1'b1; tick();
        load_n = 1'b0; tick(); load_n = 1'b1;
        chk("R6 load after clear", 64'h8000_8000_8000_1234, 8'hE2);
        // R9: clear edge drops simultaneous frame
        clear_n = 1'b0;
        send(fr(4'h3, 4'h0, 16'h4321));
        chk("R9 abort", 64'h8000_8000_8000_8000, 8'hE2);
        clear_n = 1'b1; tick();
        // R8: clear code 11 is no-op
        send(fr(4'h3, 4'h0, 16'h0123));
        send(32'h0500_0003);
        clear_n = 1'b0; tick();
        chk("R8 code11 noop", 64'h8000_8000_8000_0123, 8'hE2);
        clear_n = 1'b1; tick();
        // R11: software reset with midscale select
        rst_mid = 1'b1;
        send(fr(4'h7, 4'h0, 16'h0));
        chk("R11 soft reset", 64'h8000_8000_8000_8000, 8'h00);
        // R7: mask cleared by reset, write does not reach output
        send(fr(4'h0, 4'h1, 16'h0001));
        chk("R7 mask reset", 64'h8000_8000_8000_8000, 8'h00);
        // R8: clear code back to default 00
        clear_n = 1'b0; tick();
        chk("R8 default code", 64'h0, 8'h00);
        clear_n = 1'b1; tick();
        // R1: power-on reset with load and clear active
        send(fr(4'h3, 4'h2, 16'hAAAA));
        send(32'h0400_0101);
        chk("R10 mode01", 64'h0000_AAAA_0000_0000, 8'h01);
        rst_mid = 1'b0; rst_n = 1'b0; clear_n = 1'b0; load_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1; tick();
        chk("R1 reset under load/clear", 64'h0, 8'h00);
        load_n = 1'b1; clear_n = 1'b1; tick();
        chk("R1 no edge after reset", 64'h0, 8'h00);
        rst_mid = 1'b1; rst_n = 1'b0; repeat (2) tick();
        rst_n = 1'b1; tick();
        chk("R1 reset mid", 64'h8000_8000_8000_8000, 8'h00);
        // R5: bad address with write-and-update
        send(fr(4'h3, 4'hA, 16'h5A5A));
        chk("R5 bad addr", 64'h8000_8000_8000_8000, 8'h00);
        // R8: clear code 10 gives full scale
        send(32'h0500_0002);
        clear_n = 1'b0; tick();
        chk("R8 full scale", 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
        clear_n = 1'b1; tick();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: out=%h pwr=%h expected completion", out_code, pwr_mode);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule